// File: doc/BRIEF.md
# Break-Triggered Receiver Wake-Up Controller

This block sits between the RX pin conditioning and a UART receiver and provides a low-power wake-up on a break character. Software arms it with a set strobe, but only while the receiver reports it is idle. While armed, the block holds the receiver suspended, so the line is not framed as data. The block then watches the synchronized RX line for a falling edge.

A falling edge while armed is the wake-up event. It raises the receive interrupt flag and pulses a dummy-data load into the receive data register. The interrupt flag is cleared by the read strobe of that register. The next rising edge ends the break. The wake-enable bit then clears itself and the receiver is released. The receiver starts its next reception only on a fresh falling edge, so the rising edge that ends the break is never taken as data.

For sleep, the block also gives a combinational wake request. It is taken directly from the unsynchronized line, so it needs no clock.

Top module: `wkbrk_ctrl`

## Requirements
- R1: After synchronous reset, wake_en, wake_flag, rx_suspend and dummy_load are all 0.
- R2: An arm_stb pulse with rx_idle=1 while disarmed sets wake_en and rx_suspend at the next clock edge.
- R3: An arm_stb pulse with rx_idle=0 is ignored: wake_en and rx_suspend stay 0.
- R4: While armed, a high-to-low change of rx_line sets wake_flag and gives a one-cycle dummy_load pulse, both visible after the third rising clock edge that follows the pin change (two synchronizer flops plus the edge register).
- R5: After the wake-up event, a low-to-high change of rx_line clears wake_en and rx_suspend after the third rising clock edge that follows it.
- R6: Edges that are not wake-up events have no effect on the flags. This covers a falling edge while disarmed, and a rising edge while armed that comes before any falling edge; in the second case the block stays armed.
- R7: rd_stb clears wake_flag at the next edge. If the wake-up event and rd_stb fall in the same cycle, the set wins.
- R8: Exactly one wake_flag set and one dummy_load happen per armed period. After a read clears the flag during the break, the flag stays 0 until disarm, and later falling edges while disarmed do not set it.
- R9: wake_async equals wake_en AND NOT rx_line combinationally, with no clock involved.
- R10: arm_stb while already armed or during the break has no effect; wake_en stays 1 and no extra dummy_load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | RX line after optional polarity inversion, idle high |
| arm_stb | input | 1 | One-cycle request to set the wake-enable bit |
| rd_stb | input | 1 | Read strobe of the receive data register |
| rx_idle | input | 1 | Receiver reports no reception in progress |
| wake_en | output | 1 | Wake-enable bit, self-clearing |
| wake_flag | output | 1 | Receive interrupt flag raised by the wake-up |
| rx_suspend | output | 1 | Holds the normal receiver idle while armed |
| dummy_load | output | 1 | One-cycle load of a dummy character into the data register |
| wake_async | output | 1 | Clock-free wake request for sleep |

## Verification
The assertions check on every cycle four things:
- wake_flag only rises right after an armed falling edge.
- wake_en only rises on an accepted arm request and only falls right after a rising edge.
- A read clears the flag unless a new event coincides with it.
- dummy_load never lasts two cycles.

Only the bench scenarios can show the rest:
- the exact three-edge latency through the synchronizer;
- that rejected or repeated arm requests and stray edges leave the outputs unchanged;
- that one armed period yields one dummy load across a sweep of break lengths.

// File: rtl/wkbrk_pkg.sv
package wkbrk_pkg;
  typedef enum logic [1:0] {
    WK_RUN   = 2'd0,
    WK_ARMED = 2'd1,
    WK_BREAK = 2'd2
  } wk_state_t;
endpackage

// File: rtl/wkbrk_sync.sv
module wkbrk_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wkbrk_edge.sv
module wkbrk_edge #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= RESET_VAL;
    else     lvl_d <= lvl;
  end

  assign fall = lvl_d & ~lvl;
  assign rise = ~lvl_d & lvl;
endmodule

// File: rtl/wkbrk_fsm.sv
module wkbrk_fsm
  import wkbrk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic rise,
  input  logic arm_stb,
  input  logic rd_stb,
  input  logic rx_idle,
  output logic wake_en,
  output logic wake_flag,
  output logic rx_suspend,
  output logic dummy_load
);
  wk_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WK_RUN;
      wake_flag  <= 1'b0;
      dummy_load <= 1'b0;
    end else begin
      dummy_load <= 1'b0;
      case (state)
        WK_RUN:   if (arm_stb && rx_idle) state <= WK_ARMED;
        WK_ARMED: if (fall) begin
                    state      <= WK_BREAK;
                    dummy_load <= 1'b1;
                  end
        WK_BREAK: if (rise) state <= WK_RUN;
        default:  state <= WK_RUN;
      endcase
      if (state == WK_ARMED && fall) wake_flag <= 1'b1;
      else if (rd_stb)               wake_flag <= 1'b0;
    end
  end

  assign wake_en    = (state == WK_ARMED) || (state == WK_BREAK);
  assign rx_suspend = (state != WK_RUN);

  a_r2_arm_needs_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_en) |-> $past(arm_stb && rx_idle));
  a_r4_flag_from_event: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> $past(fall && wake_en));
  a_r5_clear_on_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_en) |-> $past(rise));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_stb) && !dummy_load) |-> !wake_flag);
  a_r8_single_load: assert property (@(posedge clk) disable iff (rst)
    dummy_load |=> !dummy_load);
endmodule

// File: rtl/wkbrk_ctrl.sv
module wkbrk_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic arm_stb,
  input  logic rd_stb,
  input  logic rx_idle,
  output logic wake_en,
  output logic wake_flag,
  output logic rx_suspend,
  output logic dummy_load,
  output logic wake_async
);
  logic rx_s, fall, rise;

  wkbrk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(rx_s));

  wkbrk_edge #(.RESET_VAL(1'b1)) u_edge (
    .clk(clk), .rst(rst), .lvl(rx_s), .fall(fall), .rise(rise));

  wkbrk_fsm u_fsm (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .arm_stb(arm_stb), .rd_stb(rd_stb), .rx_idle(rx_idle),
    .wake_en(wake_en), .wake_flag(wake_flag),
    .rx_suspend(rx_suspend), .dummy_load(dummy_load));

  // R9: clock-free request for sleep
  assign wake_async = wake_en & ~rx_line;

  a_r9_async_follows_pin: assert property (@(posedge clk) disable iff (rst)
    (wake_en && !rx_line) |-> wake_async);
endmodule

// File: tb/sim_wkbrk_ctrl.sv
`timescale 1ns/1ps
module sim_wkbrk_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1, arm_stb = 1'b0, rd_stb = 1'b0, rx_idle = 1'b1;
  logic wake_en, wake_flag, rx_suspend, dummy_load, wake_async;
  int checks = 0, errors = 0, loads = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wkbrk_ctrl u0 (.clk(clk), .rst(rst), .rx_line(rx_line), .arm_stb(arm_stb),
    .rd_stb(rd_stb), .rx_idle(rx_idle), .wake_en(wake_en), .wake_flag(wake_flag),
    .rx_suspend(rx_suspend), .dummy_load(dummy_load), .wake_async(wake_async));

  always @(negedge clk) if (!rst && dummy_load) loads++;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic arm();
    arm_stb = 1'b1; tick(1); arm_stb = 1'b0;
  endtask

  task automatic rd();
    rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    tick(3); rst = 1'b0; tick(1);
    chk("R1 wake_en", wake_en, 0); chk("R1 flag", wake_flag, 0);
    chk("R1 suspend", rx_suspend, 0); chk("R1 dummy", dummy_load, 0);

    rx_idle = 1'b0; arm(); rx_idle = 1'b1;
    chk("R3 wake_en", wake_en, 0); chk("R3 suspend", rx_suspend, 0);

    rx_line = 1'b0; tick(4);
    chk("R6 fall disarmed flag", wake_flag, 0); chk("R6 dummy", loads == 0, 1);
    rx_line = 1'b1; tick(4);

    arm();
    chk("R2 wake_en", wake_en, 1); chk("R2 suspend", rx_suspend, 1);
    rx_line = 1'b0; #1;
    chk("R9 async", wake_async, 1);
    tick(2);
    chk("R4 flag early", wake_flag, 0);
    tick(1);
    chk("R4 flag", wake_flag, 1); chk("R4 dummy", dummy_load, 1);
    tick(1);
    chk("R4 dummy one cycle", dummy_load, 0);
    arm();
    chk("R10 wake_en", wake_en, 1);
    rd();
    chk("R7 cleared", wake_flag, 0);
    tick(5);
    chk("R8 no retrigger", wake_flag, 0); chk("R10 loads", loads == 1, 1);
    rx_line = 1'b1; tick(2);
    chk("R5 still armed", wake_en, 1);
    tick(1);
    chk("R5 wake_en clear", wake_en, 0); chk("R5 suspend clear", rx_suspend, 0);
    #1; chk("R9 async low", wake_async, 0);
    tick(1);
    rx_line = 1'b0; tick(4);
    chk("R8 no flag after disarm", wake_flag, 0);
    rx_line = 1'b1; tick(4);

    arm(); rx_line = 1'b0; tick(2); rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
    chk("R7 set wins", wake_flag, 1);
    rx_line = 1'b1; tick(4); rd(); tick(1);
    chk("R7 read later", wake_flag, 0);

    rx_line = 1'b0; tick(4); arm();
    rx_line = 1'b1; tick(4);
    chk("R6 rise armed keeps", wake_en, 1); chk("R6 rise no flag", wake_flag, 0);
    rx_line = 1'b0; tick(4);
    chk("R4 after rise", wake_flag, 1);
    rd(); rx_line = 1'b1; tick(4);
    chk("R5 disarmed", wake_en, 0);

    for (int len = 1; len <= 8; len++) begin
      base = loads;
      arm(); rx_line = 1'b0; tick(len); rx_line = 1'b1; tick(2);
      chk("R5 sweep armed", wake_en, 1);
      tick(1);
      chk("R5 sweep clear", wake_en, 0); chk("R4 sweep flag", wake_flag, 1);
      tick(2);
      chk("R8 sweep one load", (loads - base) == 1, 1);
      rd(); tick(1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule